// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by holding a 7-bit down-counter that must be reloaded neither too late nor too early. The counter steps down on a slow tick made by dividing the bus clock by a fixed power of two and then by 1, 2, 4 or 8. If the count would fall below 0x40, the block requests a system reset. It also requests one when software reloads while the count is still above a programmed window value. Reloading inside the window keeps the system alive. An optional early-warning interrupt fires one step before the timeout, so software can save state or move to a safe mode.

Software reaches the block through a small register port with write strobe, a 2-bit address and a combinational read path. Three registers are decoded: control (counter value and enable), configuration (window, divider select, early-warning enable) and status (the early-warning flag). Once armed, the block cannot be switched off by software. After a reset request, it goes back to its reset state on its own.

The control state machine has three states. OFF is disarmed. RUN is counting. FIRE drives the one-cycle reset request. The transitions are:
- arm: OFF to RUN, on a valid enabling write.
- arm-fault: OFF to FIRE, on an enabling write whose bit 6 is clear.
- reload: RUN to RUN, on a valid write inside the window.
- reload-fault: RUN to FIRE, on a write that is too early or whose bit 6 is clear.
- expire: RUN to FIRE, on a tick while the count is 0x40.
- recover: FIRE to OFF, always.

Top module: `wwdt_top`

## Requirements
- R1: After reset the block is disarmed. The counter reads 0x7F. The window reads 0x7F, the divider select 0, the early-warning enable 0 and the flag 0. Both reset_req and irq are low.
- R2: A write to address 0 with bit 7 set and bit 6 set loads bits 6:0 into the counter and arms the block. Reads of address 0 return {armed, counter} in bits 7:0. A write to address 0 with bit 7 clear is ignored in every state, so an armed block stays armed.
- R3: While armed, the counter decreases by one once every 2^BASE_LOG2 * 2^sel cycles, counted from the arming write. Here sel is configuration bits 8:7, written at address 1.
- R4: A tick that arrives while the count is 0x40 raises reset_req in the following cycle.
- R5: An enabling write at address 0 while the armed count is greater than the window (configuration bits 6:0) raises reset_req in the following cycle. An enabling write while the count is at or below the window reloads the counter.
- R6: An enabling write whose bit 6 is clear raises reset_req in the following cycle, whether the block is disarmed or armed.
- R7: When a tick moves the count from 0x41 to 0x40 and configuration bit 9 is set, the flag (status bit 0 at address 2) is set. irq equals the flag while armed. Writing status bit 0 as 0 clears the flag. Writing it as 1 has no effect.
- R8: reset_req lasts exactly one cycle. In the next cycle every register is back at its R1 value.
- R9: An enabling write in the same cycle as a tick takes priority, and that tick is dropped.
- R10: While disarmed, the counter holds 0x7F and neither output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select: 0 control, 1 configuration, 2 status |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | 10 | Write data |
| rdata | output | 10 | Read data of the addressed register (combinational) |
| reset_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Early-warning interrupt |

## Verification
Directed sequences cover several situations:
- letting the counter run out, which separates an off-by-one in the tick period from a wrong timeout threshold;
- reloading above and below the window, which separates an inclusive window compare from an exclusive one;
- writing a value with bit 6 clear, both disarmed and armed;
- placing a reload exactly on a tick cycle, which shows whether the write or the decrement wins.

Random episodes then program random windows, divider selects and interrupt enables. Reloads and flag writes arrive at random times, and the read address moves around, so early, in-window and late reloads all mix with flag set and clear collisions. A cycle-level reference model in the bench compares every output on every cycle.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wd_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CFG  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

endpackage

// File: rtl/wwdt_tick_gen.sv
module wwdt_tick_gen #(
    parameter int BASE_LOG2 = 12,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [BASE_LOG2-1:0] base_q;
    logic [PRE_W-1:0]     pre_q;
    logic [PRE_W-1:0]     mask;
    logic                 base_tick;

    always_comb begin
        mask      = PRE_W'((32'd1 << sel) - 32'd1);
        base_tick = run && (&base_q);
        tick      = base_tick && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            base_q <= '0;
            pre_q  <= '0;
        end else begin
            base_q <= base_q + 1'b1;
            if (base_tick) begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '1;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/wwdt_cfg_regs.sv
module wwdt_cfg_regs #(
    parameter int CNT_W = 7,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] win_in,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             ie_in,
    input  logic             flag_set,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] win,
    output logic [SEL_W-1:0] sel,
    output logic             ie,
    output logic             flag
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            win <= '1;
            sel <= '0;
            ie  <= 1'b0;
        end else if (cfg_we) begin
            win <= win_in;
            sel <= sel_in;
            ie  <= ie_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            flag <= 1'b0;
        end else if (flag_set) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
    import wwdt_pkg::*;
#(
    parameter int CNT_W     = 7,
    parameter int BASE_LOG2 = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   addr,
    input  logic                         wr_en,
    input  logic [CNT_W+2:0]             wdata,
    output logic [CNT_W+2:0]             rdata,
    output logic                         reset_req,
    output logic                         irq
);
    localparam int SEL_W  = 2;
    localparam int REG_W  = CNT_W + SEL_W + 1;
    localparam int EN_BIT = CNT_W;
    localparam int IE_BIT = CNT_W + SEL_W;
    localparam logic [CNT_W-1:0] CNT_FLOOR = CNT_W'(1 << (CNT_W - 1));
    localparam logic [CNT_W-1:0] CNT_WARN  = CNT_FLOOR + 1'b1;

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, win_q, new_val;
    logic [SEL_W-1:0] sel_q;
    logic             ie_q, flag_q, tick;
    logic             wr_ctrl, wr_cfg, wr_stat, en_req, val_ok, early, at_floor;
    logic             active, firing, load, dec, warn_set, flag_clr;

    // register port decode
    always_comb begin
        wr_ctrl  = wr_en && (addr == A_CTRL);
        wr_cfg   = wr_en && (addr == A_CFG);
        wr_stat  = wr_en && (addr == A_STAT);
        new_val  = wdata[CNT_W-1:0];
        en_req   = wr_ctrl && wdata[EN_BIT];
        val_ok   = new_val[CNT_W-1];
        early    = cnt_q > win_q;
        at_floor = (cnt_q == CNT_FLOOR);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_req) begin
                    state_d = val_ok ? ST_RUN : ST_FIRE;   // arm / arm-fault
                end
            end
            ST_RUN: begin
                if (en_req) begin
                    state_d = (early || !val_ok) ? ST_FIRE : ST_RUN; // reload / reload-fault
                end else if (tick && at_floor) begin
                    state_d = ST_FIRE;                     // expire
                end
            end
            ST_FIRE: state_d = ST_OFF;                     // recover
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and datapath controls
    always_comb begin
        active    = (state_q == ST_RUN);
        firing    = (state_q == ST_FIRE);
        reset_req = firing;
        irq       = flag_q && active;
        load      = en_req && val_ok && ((state_q == ST_OFF) || (active && !early));
        dec       = active && tick && !en_req && !at_floor;
        warn_set  = dec && (cnt_q == CNT_WARN) && ie_q;
        flag_clr  = wr_stat && !wdata[0];
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = REG_W'({active, cnt_q});
            A_CFG:   rdata = {ie_q, sel_q, win_q};
            A_STAT:  rdata = REG_W'(flag_q);
            default: rdata = '0;
        endcase
    end

    wwdt_tick_gen #(
        .BASE_LOG2 (BASE_LOG2),
        .SEL_W     (SEL_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active),
        .sel   (sel_q),
        .tick  (tick)
    );

    wwdt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (firing),
        .load     (load),
        .load_val (new_val),
        .dec      (dec),
        .cnt      (cnt_q)
    );

    wwdt_cfg_regs #(
        .CNT_W (CNT_W),
        .SEL_W (SEL_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (firing),
        .cfg_we   (wr_cfg),
        .win_in   (wdata[CNT_W-1:0]),
        .sel_in   (wdata[IE_BIT-1:CNT_W]),
        .ie_in    (wdata[IE_BIT]),
        .flag_set (warn_set),
        .flag_clr (flag_clr),
        .win      (win_q),
        .sel      (sel_q),
        .ie       (ie_q),
        .flag     (flag_q)
    );

endmodule

// File: rtl/wwdt_top_chk.sv
module wwdt_top_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reset_req,
    input logic             active,
    input logic             tick,
    input logic             en_req,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] win
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(1 << (CNT_W - 1));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    p_back_to_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (!active && cnt == '1));

    p_floor_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> cnt[CNT_W-1]);

    p_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && !en_req && cnt == FLOOR) |=> reset_req);

    p_early_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && en_req && cnt > win) |=> reset_req);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !reset_req) |-> cnt == '1);

    p_step_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !en_req) |=> (reset_req || cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

endmodule

bind wwdt_top wwdt_top_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_req (reset_req),
    .active    (active),
    .tick      (tick),
    .en_req    (en_req),
    .cnt       (cnt_q),
    .win       (win_q)
);

// File: tb/wwdt_top_test.sv
module wwdt_top_test;
    localparam int CNT_W = 7;
    localparam int BASE_LOG2 = 3;
    localparam int D = 1 << BASE_LOG2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [9:0] wdata = '0;
    logic [9:0] rdata;
    logic       reset_req, irq;

    always #4 clk = ~clk;

    wwdt_top #(.CNT_W(CNT_W), .BASE_LOG2(BASE_LOG2)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .reset_req(reset_req), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model: 0 disarmed, 1 armed, 2 firing
    int m_st, m_cnt, m_win, m_sel, m_ie, m_flag, m_cyc;

    task automatic model_reset();
        m_st = 0; m_cnt = 127; m_win = 127; m_sel = 0; m_ie = 0; m_flag = 0; m_cyc = 0;
    endtask

    function automatic int exp_rdata(int a);
        case (a)
            0: return ((m_st == 1) ? 128 : 0) | m_cnt;
            1: return (m_ie << 9) | (m_sel << 7) | m_win;
            2: return m_flag;
            default: return 0;
        endcase
    endfunction

    task automatic model_step(int a, bit we, logic [9:0] wd);
        int  p, nst, ncnt;
        bit  tk, en, setf;
        if (m_st == 2) begin
            model_reset();
            return;
        end
        p    = D << m_sel;
        tk   = (m_st == 1) && ((m_cyc % p) == p - 1);
        en   = we && (a == 0) && wd[7];
        nst  = m_st;
        ncnt = m_cnt;
        setf = 0;
        if (en) begin
            if (m_st == 0) begin
                if (wd[6]) begin nst = 1; ncnt = int'(wd[6:0]); end
                else nst = 2;
            end else begin
                if (m_cnt > m_win || !wd[6]) nst = 2;
                else ncnt = int'(wd[6:0]);
            end
        end else if (tk) begin
            if (m_cnt == 64) nst = 2;
            else begin
                ncnt = m_cnt - 1;
                if (m_cnt == 65 && m_ie == 1) setf = 1;
            end
        end
        if (setf) m_flag = 1;
        else if (we && a == 2 && !wd[0]) m_flag = 0;
        if (we && a == 1) begin
            m_win = int'(wd[6:0]); m_sel = int'(wd[8:7]); m_ie = int'(wd[9]);
        end
        if (m_st == 1 && nst == 1) m_cyc = m_cyc + 1;
        else m_cyc = 0;
        m_st  = nst;
        m_cnt = ncnt;
    endtask

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(logic [1:0] a, bit we, logic [9:0] wd, string req);
        @(negedge clk);
        addr = a; wr_en = we; wdata = wd;
        @(posedge clk);
        #1;
        model_step(int'(a), we, wd);
        check(req, int'(reset_req), (m_st == 2) ? 1 : 0, "reset_req");
        check(req, int'(irq), (m_flag == 1 && m_st == 1) ? 1 : 0, "irq");
        check(req, int'(rdata), exp_rdata(int'(a)), "rdata");
    endtask

    task automatic run_to_fire(string req, int limit);
        int n;
        n = 0;
        while (m_st != 2 && n < limit) begin
            step(2'(n % 3), 1'b0, '0, req);
            n++;
        end
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL R3 watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int r;
        r = int'($urandom(32'd9173));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values of every register
        step(2'd0, 1'b0, '0, "R1");
        step(2'd1, 1'b0, '0, "R1");
        step(2'd2, 1'b0, '0, "R1");

        // R10 / R2: writes without enable bit leave the block disarmed
        step(2'd0, 1'b1, 10'h033, "R10");
        repeat (20) step(2'd0, 1'b0, '0, "R10");

        // R3 R4 R7: run out with sel=1 and early warning on
        step(2'd1, 1'b1, 10'h2FF, "R3");
        step(2'd0, 1'b1, 10'h0C2, "R2");
        run_to_fire("R3 R4 R7", 200);
        step(2'd0, 1'b0, '0, "R8");
        step(2'd1, 1'b0, '0, "R8");

        // R6: invalid value while disarmed
        step(2'd0, 1'b1, 10'h0A0, "R6");
        step(2'd0, 1'b0, '0, "R8");

        // R7: flag set, write 1 ignored, write 0 clears
        step(2'd1, 1'b1, 10'h27F, "R7");
        step(2'd0, 1'b1, 10'h0C1, "R2");
        while (m_flag == 0 && m_st == 1) step(2'd2, 1'b0, '0, "R7");
        step(2'd2, 1'b1, 10'h001, "R7");
        step(2'd2, 1'b1, 10'h000, "R7");
        // R5: reload inside window accepted
        step(2'd0, 1'b1, 10'h0FF, "R5");
        // R2: enable bit clear cannot disarm
        step(2'd0, 1'b1, 10'h055, "R2");
        // R6: invalid value while armed
        step(2'd0, 1'b1, 10'h0B0, "R6");
        step(2'd0, 1'b0, '0, "R8");

        // R5: early reload above window
        step(2'd1, 1'b1, 10'h050, "R5");
        step(2'd0, 1'b1, 10'h0FF, "R2");
        step(2'd0, 1'b1, 10'h0FF, "R5");
        step(2'd0, 1'b0, '0, "R8");

        // R9: reload on the tick cycle at count 0x40
        step(2'd1, 1'b1, 10'h07F, "R9");
        step(2'd0, 1'b1, 10'h0C0, "R2");
        while ((m_cyc % D) != D - 1) step(2'd0, 1'b0, '0, "R9");
        step(2'd0, 1'b1, 10'h0FF, "R9");
        step(2'd0, 1'b0, '0, "R9");
        step(2'd0, 1'b1, 10'h080, "R6");
        step(2'd0, 1'b0, '0, "R8");

        // random episodes
        for (int ep = 0; ep < 25; ep++) begin
            int first, n, pick;
            step(2'd1, 1'b1, 10'((($urandom % 2) << 9) | (($urandom % 4) << 7) | (64 + $urandom % 64)), "R3");
            first = (($urandom % 8) == 0) ? int'($urandom % 64) : int'(64 + $urandom % 64);
            step(2'd0, 1'b1, 10'(128 | first), "R2");
            n = 0;
            while (m_st != 2 && n < 3000) begin
                pick = int'($urandom % 100);
                if (pick < 3) step(2'd0, 1'b1, 10'(128 | (64 + $urandom % 64)), "R5");
                else if (pick < 5) step(2'd2, 1'b1, 10'($urandom % 2), "R7");
                else step(2'($urandom % 3), 1'b0, '0, "R3");
                n++;
            end
            step(2'd0, 1'b0, '0, "R8");
        end

        @(negedge clk) wr_en = 1'b0;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule